// File: doc/BRIEF.md
# GPIO Port Register Block

This block is the register front end of one general-purpose I/O port of up to 16 pins. A bus master talks to it through single-cycle write and read strobes, a word address and 32-bit data. For each pin it holds a mode code, an output data bit, an output write-protect bit, a pull-up enable and a disable for the digital input path. From these it drives the pad output value, the pad output enable and the pull-up control. Pad electrical behaviour stays outside the block. Open-drain and pull-up only shape control outputs. Interrupt detection and debounce live in a separate block.

Pin levels pass through a synchroniser before any read can see them. The upper half of the address space is a bit-addressed window. Each pin of each port has its own word there, so one pin can be read or written without a read-modify-write of the port word. Only the words whose port field matches the PORT_IDX parameter belong to this instance.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset every register reads 0: all pins are inputs, output data, write-protect and pull-up bits are 0, and the input path is enabled. pad_oe, pad_out and pull_en are all 0.
- R2: The mode register is control word 0 and holds 2 bits per pin, with pin n at bits 2n+1:2n. Code 0 (input) and code 3 (reserved) drive pad_oe low. Code 1 (push-pull) drives pad_oe high. Code 2 (open-drain) drives pad_oe high only while that pin's output bit is 0. pad_out always equals the output data bits.
- R3: A write to the output data register (control word 1) updates only the pins whose bit in the write-protect register (control word 2) is 0. Protected pins keep their output bit. Both registers read back their stored values.
- R4: Control word 4 reads the pin levels after a two-flop synchroniser. A pin change applied before clock edge k is first captured by a read strobed at edge k+2. A read strobed at edge k+1 still returns the old level. Read data is registered and appears one cycle after the read strobe. Writes to control word 4 have no effect.
- R5: The input-path disable register is control word 5. Pin n sits at bit n+16, and bits 15:0 read as 0 and ignore writes. A disabled pin reads 0 in control word 4 and in its window word.
- R6: The pull-up register is control word 3, one bit per pin. Bit n drives pull_en[n].
- R7: Addresses with bit 7 set form the pin window: bits 6:4 are the port field and bits 3:0 the pin number. A read of a window word whose port field equals PORT_IDX returns that pin's synchronised, input-gated level in bit 0, with bits 31:1 at 0.
- R8: A write to a window word whose port field equals PORT_IDX sets that pin's output bit to bit 0 of the write data. The write-protect register does not apply, and the other pins keep their bits.
- R9: Window words whose port field differs from PORT_IDX read as 0, and writes to them change no output bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | ADDR_W (8) | Word address: bit 7 selects the pin window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, valid the cycle after rd_en |
| pin_in | input | PINS (16) | Raw pin levels from the pads |
| pad_out | output | PINS (16) | Pad output value |
| pad_oe | output | PINS (16) | Pad output enable |
| pull_en | output | PINS (16) | Pull-up control |

## Verification
The output data register is written with several write-protect patterns: none, a nibble, and protection combined with window writes. These show that masking acts on port writes but not on window writes. Mode codes are set on neighbouring pins and output bits are toggled between them, which tells push-pull from open-drain from reserved. Pin levels are read one cycle too early and then in time, with part of the input path disabled. This checks the synchroniser depth and the gating bit position. Window reads and writes target pins of this port and of a foreign port, which shows that the port field is decoded.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   typedef enum logic [1:0] {
      PM_IN  = 2'd0,
      PM_PP  = 2'd1,
      PM_OD  = 2'd2,
      PM_RSV = 2'd3
   } pin_mode_e;

   // control word indices (address bit 7 clear)
   localparam int W_MODE  = 0;
   localparam int W_DOUT  = 1;
   localparam int W_MASK  = 2;
   localparam int W_PULL  = 3;
   localparam int W_INPUT = 4;
   localparam int W_INOFF = 5;

   // pin window: 16 words per port, giving a 0x40 byte stride
   localparam int SLOT_AW   = 4;
   localparam int INOFF_LSB = 16;
   localparam int DATA_W    = 32;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_depth
      $error("gpio_sync needs at least two stages");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
   import gpio_pkg::*;
#(
   parameter int PINS = 16
) (
   input  logic [2*PINS-1:0] mode,
   input  logic [PINS-1:0]   dout,
   output logic [PINS-1:0]   oe
);
   for (genvar p = 0; p < PINS; p++) begin : g_pin
      pin_mode_e m;
      logic      en;
      assign m = pin_mode_e'(mode[2*p +: 2]);
      always_comb begin
         case (m)
            PM_PP:   en = 1'b1;
            PM_OD:   en = ~dout[p];
            default: en = 1'b0;
         endcase
      end
      assign oe[p] = en;
   end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
   import gpio_pkg::*;
#(
   parameter int PINS        = 16,
   parameter int ADDR_W      = 8,
   parameter int PORT_IDX    = 0,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   input  logic [PINS-1:0]   pin_in,
   output logic [PINS-1:0]   pad_out,
   output logic [PINS-1:0]   pad_oe,
   output logic [PINS-1:0]   pull_en
);
   localparam int PW = ADDR_W - 1 - SLOT_AW;

   if (PINS < 1 || PINS > 16) begin : g_bad_pins
      $error("PINS must be 1..16");
   end
   if (PW < 1) begin : g_bad_addr
      $error("ADDR_W too small for the pin window");
   end
   if (PORT_IDX < 0 || PORT_IDX >= (1 << PW)) begin : g_bad_port
      $error("PORT_IDX does not fit the port field");
   end

   logic [2*PINS-1:0] mode_q;
   logic [PINS-1:0]   dout_q, dmask_q, pull_q, inoff_q;
   logic [PINS-1:0]   sync_lvl, level;
   logic [31:0]       rdata_q, rd_mux;

   // address decode
   logic              is_alias, alias_hit;
   logic [PW-1:0]     port_f;
   logic [SLOT_AW-1:0] slot;
   logic [ADDR_W-2:0] ctl_word;
   logic sel_mode, sel_dout, sel_mask, sel_pull, sel_input, sel_inoff;

   assign is_alias  = addr[ADDR_W-1];
   assign port_f    = addr[ADDR_W-2:SLOT_AW];
   assign slot      = addr[SLOT_AW-1:0];
   assign ctl_word  = addr[ADDR_W-2:0];
   assign alias_hit = is_alias && (port_f == PW'(PORT_IDX)) && (int'(slot) < PINS);

   always_comb begin
      sel_mode  = !is_alias && int'(ctl_word) == W_MODE;
      sel_dout  = !is_alias && int'(ctl_word) == W_DOUT;
      sel_mask  = !is_alias && int'(ctl_word) == W_MASK;
      sel_pull  = !is_alias && int'(ctl_word) == W_PULL;
      sel_input = !is_alias && int'(ctl_word) == W_INPUT;
      sel_inoff = !is_alias && int'(ctl_word) == W_INOFF;
   end

   // register writes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= '0;
         dout_q  <= '0;
         dmask_q <= '0;
         pull_q  <= '0;
         inoff_q <= '0;
      end else if (wr_en) begin
         if (sel_mode)  mode_q  <= wdata[2*PINS-1:0];
         if (sel_dout)  dout_q  <= (dout_q & dmask_q) | (wdata[PINS-1:0] & ~dmask_q);
         if (sel_mask)  dmask_q <= wdata[PINS-1:0];
         if (sel_pull)  pull_q  <= wdata[PINS-1:0];
         if (sel_inoff) inoff_q <= wdata[INOFF_LSB +: PINS];
         if (alias_hit) dout_q[slot] <= wdata[0];
      end
   end

   // input path
   gpio_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (sync_lvl)
   );

   assign level = sync_lvl & ~inoff_q;

   // read path
   always_comb begin
      rd_mux = '0;
      if (alias_hit)      rd_mux[0] = level[slot];
      else if (sel_mode)  rd_mux[2*PINS-1:0] = mode_q;
      else if (sel_dout)  rd_mux[PINS-1:0] = dout_q;
      else if (sel_mask)  rd_mux[PINS-1:0] = dmask_q;
      else if (sel_pull)  rd_mux[PINS-1:0] = pull_q;
      else if (sel_input) rd_mux[PINS-1:0] = level;
      else if (sel_inoff) rd_mux[INOFF_LSB +: PINS] = inoff_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata_q <= '0;
      else if (rd_en) rdata_q <= rd_mux;
   end

   assign rdata = rdata_q;

   // pad control
   gpio_pad_ctrl #(.PINS(PINS)) u_pad (
      .mode (mode_q),
      .dout (dout_q),
      .oe   (pad_oe)
   );

   assign pad_out = dout_q;
   assign pull_en = pull_q;

   // R3
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel_dout) |=> (((dout_q ^ $past(dout_q)) & $past(dmask_q)) == '0));

   // R5
   inoff_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && sel_input) |=> ((rdata_q[PINS-1:0] & $past(inoff_q)) == '0));

   // R8
   alias_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && alias_hit) |=> (dout_q[$past(slot)] == $past(wdata[0])));

   // R9
   foreign_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && is_alias && !alias_hit) |=> $stable(dout_q));

   for (genvar p = 0; p < PINS; p++) begin : g_od_chk
      // R2
      od_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_q[2*p +: 2] == PM_OD && dout_q[p]) |-> !pad_oe[p]);
   end
endmodule

// File: tb/tb_gpio_port_regs.sv
module tb_gpio_port_regs;
   localparam int PINS = 16;
   localparam int PORT = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [15:0] pin_in = '0;
   logic [15:0] pad_out, pad_oe, pull_en;

   int checks = 0, errors = 0;
   bit done = 0;

   typedef struct { logic [31:0] val; string tag; } exp_t;
   exp_t sb[$];

   always #10 clk = ~clk;

   gpio_port_regs #(.PINS(PINS), .ADDR_W(8), .PORT_IDX(PORT)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pad_out(pad_out),
      .pad_oe(pad_oe), .pull_en(pull_en));

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
      exp_t e;
      @(negedge clk);
      e.val = exp; e.tag = tag;
      sb.push_back(e);
      addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   // monitor: compares registered read data one cycle after each strobe
   initial begin
      forever begin
         @(posedge clk);
         if (rd_en) begin
            @(negedge clk);
            if (sb.size() == 0) check(rdata, 32'hDEAD_BEEF, "scoreboard empty");
            else begin
               exp_t e;
               e = sb.pop_front();
               check(rdata, e.val, e.tag);
            end
         end
      end
   end

   function automatic logic [7:0] win(input int port, input int pin);
      return 8'h80 | 8'((port << 4) | pin);
   endfunction

   logic [15:0] m_dout, m_mask;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(32'(pad_oe), 0, "R1 pad_oe");
      check(32'(pad_out), 0, "R1 pad_out");
      check(32'(pull_en), 0, "R1 pull_en");
      rd(8'd0, 0, "R1 mode");
      rd(8'd1, 0, "R1 dout");
      rd(8'd2, 0, "R1 mask");
      rd(8'd5, 0, "R1 inoff");

      // R2 modes: pin0 push-pull, pin1 open-drain, pin2 reserved
      wr(8'd0, 32'h0000_0039);
      rd(8'd0, 32'h39, "R2 mode readback");
      wr(8'd1, 32'h0000_0007);
      m_dout = 16'h0007;
      check(32'(pad_oe), 32'h1, "R2 oe with out=1");
      check(32'(pad_out), 32'h7, "R2 pad_out");
      wr(8'd1, 32'h0);
      m_dout = 16'h0;
      check(32'(pad_oe), 32'h3, "R2 oe with out=0");

      // R3 masked port writes
      m_mask = 16'h00F0;
      wr(8'd2, 32'(m_mask));
      wr(8'd1, 32'h1234);
      m_dout = (m_dout & m_mask) | (16'h1234 & ~m_mask);
      wr(8'd1, 32'hFFFF);
      m_dout = (m_dout & m_mask) | (16'hFFFF & ~m_mask);
      rd(8'd1, 32'(m_dout), "R3 dout masked");
      check(32'(pad_out), 32'h0000_FF0F, "R3 pad_out");
      rd(8'd2, 32'h00F0, "R3 mask readback");

      // R6 pull-up
      wr(8'd3, 32'hA5A5);
      check(32'(pull_en), 32'hA5A5, "R6 pull_en");

      // R4 synchroniser latency
      @(negedge clk);
      pin_in = 16'hBEEF;
      rd(8'd4, 32'h0, "R4 early read old level");
      repeat (2) @(negedge clk);
      rd(8'd4, 32'hBEEF, "R4 input level");
      wr(8'd4, 32'h0);
      rd(8'd4, 32'hBEEF, "R4 input write ignored");

      // R5 input disable, pins 0..7 at bits 23:16
      wr(8'd5, 32'h00FF_FFFF);
      rd(8'd5, 32'h00FF_0000, "R5 inoff readback");
      rd(8'd4, 32'hBE00, "R5 gated input");

      // R7 window reads
      rd(win(PORT, 9), 32'h1, "R7 pin9");
      rd(win(PORT, 8), 32'h0, "R7 pin8");
      rd(win(PORT, 12), 32'h1, "R7 pin12");
      rd(win(PORT, 3), 32'h0, "R5 disabled pin3 window");

      // R8 window writes bypass mask
      wr(win(PORT, 5), 32'h1);
      m_dout[5] = 1'b1;
      wr(win(PORT, 15), 32'hFFFF_FFFE);
      m_dout[15] = 1'b0;
      check(32'(pad_out), 32'(m_dout), "R8 window write");
      rd(8'd1, 32'(m_dout), "R8 dout readback");

      // R9 foreign port window
      wr(win(PORT + 1, 0), 32'h1);
      wr(win(PORT - 1, 5), 32'h0);
      check(32'(pad_out), 32'(m_dout), "R9 foreign write ignored");
      rd(win(PORT + 1, 9), 32'h0, "R9 foreign read zero");

      repeat (3) @(negedge clk);
      if (sb.size() != 0) check(32'(sb.size()), 0, "scoreboard drained");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule